// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial slave that a host programs through fixed 16-bit frames on a mode-0 SPI link. The block samples the serial pins with its own system clock. Each completed frame carries an opcode, a register address, a data byte and a parity bit. Six opcodes are command-only controls. They set or clear the clamp output, enter sleep, hold or release the gain tracking, or soft-reset the block. The other two opcodes read and write a small register file.

The register file holds six configuration bytes and one column-check byte. Each entry is nine bits: the data byte plus an odd row-parity bit. A status word is decoded at the address after the check byte. A write that fails its row-parity check is refused and recorded. The column check is recomputed from the stored entries at all times. Read data comes back on SDO during the following frame. A frame is acted on only after all sixteen bits have arrived. Raising chip select part-way through a frame throws the frame away.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame is 16 bits. SDI is captured on each rising SCLK edge while `cs_n` is low, most significant bit first. Bits [15:13] are the opcode, [12:9] the address, [8:1] the data byte and [0] the parity bit. The frame acts once its sixteenth bit is captured.
- R2: If `cs_n` rises after 1 to 15 bits of a frame, that frame has no effect, and any read data not yet shifted out is dropped (SDO returns low).
- R3: Opcode 000 sets `clamp_en`. Opcode 001 clears it.
- R4: Opcode 010 sets `sleep_mode`. Every other opcode clears it and also performs its own action.
- R5: Opcode 011 sets `agc_hold`. Opcode 100 clears it.
- R6: Opcode 101 pulses `soft_rst` high for one clock. It also clears `clamp_en`, `agc_hold` and `row_err`, and restores every register to its reset value.
- R7: Opcode 111 to address 0..6 stores the data byte and parity bit only when the 9 bits hold an odd number of ones. Otherwise the entry is unchanged and `row_err` is set; it stays set until a soft reset.
- R8: A write to address 7 or above changes nothing and does not set `row_err`. A read of address 8 or above returns all zeros.
- R9: Opcode 110 makes the next frame shift out, on SDO, the addressed data byte (MSB first) followed by its parity bit and then seven zeros. Each bit is valid before the rising edge that would capture it. Outside such a read, SDO is low.
- R10: `col_err` is high exactly when, at some bit position, the XOR of the data bytes at addresses 0..6 is 0.
- R11: Address 7 reads as the status byte {3'b000, agc_hold, clamp_en, sleep_mode, col_err, row_err} with odd parity. The values are those present before the read frame's own effect.
- R12: After `rst_n` is released, the outputs are low, addresses 0..5 hold 0x00 with parity 1, and address 6 holds 0xFF with parity 1.
- R13: For opcodes 000..101, the address, data and parity fields do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| clamp_en | output | 1 | Modulation clamp enable |
| sleep_mode | output | 1 | Sleep request |
| agc_hold | output | 1 | Hold current gain level |
| soft_rst | output | 1 | One-clock pulse on a soft-reset command |
| row_err | output | 1 | Sticky flag for a refused write |
| col_err | output | 1 | Column check failing |

## Verification
The stimulus is a long stream of seeded random frames over all eight opcodes. Addresses include the unused range, and about one write in five carries a wrong parity bit. This stream separates correct decoding of each opcode from decoding that is off by one field position, and it exposes any difference between the column check and a reference XOR over the stored bytes. Truncated frames are mixed into the stream and must leave every output and the following read data untouched, which catches a frame that acts on a partial count. Directed frames cover the reset contents, writes to the status and unused addresses, command frames with junk fields, and wake-up from sleep by a non-sleep opcode.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
   typedef enum logic [2:0] {
      OP_CLAMP_ON  = 3'd0,
      OP_CLAMP_OFF = 3'd1,
      OP_SLEEP     = 3'd2,
      OP_AGC_ON    = 3'd3,
      OP_AGC_OFF   = 3'd4,
      OP_SRST      = 3'd5,
      OP_READ      = 3'd6,
      OP_WRITE     = 3'd7
   } op_e;

   localparam int OP_W = 3;
endpackage

// File: rtl/spi_cfg_link.sv
// Oversampling serial front end: pin synchronisers, bit counter, capture and
// transmit shift registers.
module spi_cfg_link #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               sdi,
   input  logic               tx_load,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame,
   output logic               sdo
);
   localparam int CW = $clog2(FRAME_W);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("FRAME_W must be at least 2");
   end

   logic [1:0]         sclk_q, cs_q, sdi_q;
   logic               sclk_d;
   logic [CW-1:0]      cnt;
   logic [FRAME_W-1:0] sh, tx;
   logic               rise, fall;

   assign rise  = sclk_q[1] & ~sclk_d;
   assign fall  = ~sclk_q[1] & sclk_d;
   assign frame = sh;
   assign sdo   = tx[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q     <= '0;
         cs_q       <= 2'b11;
         sdi_q      <= '0;
         sclk_d     <= 1'b0;
         cnt        <= '0;
         sh         <= '0;
         tx         <= '0;
         frame_done <= 1'b0;
      end else begin
         sclk_q     <= {sclk_q[0], sclk};
         cs_q       <= {cs_q[0], cs_n};
         sdi_q      <= {sdi_q[0], sdi};
         sclk_d     <= sclk_q[1];
         frame_done <= 1'b0;
         if (cs_q[1]) begin
            cnt <= '0;
            if (cnt != '0) tx <= '0;
         end else if (rise) begin
            sh <= {sh[FRAME_W-2:0], sdi_q[1]};
            if (cnt == CW'(FRAME_W - 1)) begin
               cnt        <= '0;
               frame_done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (fall && cnt != '0) begin
            tx <= tx << 1;
         end
         if (tx_load) tx <= tx_word;
      end
   end

   // R2: chip select rising mid-frame clears count and pending read data
   a_r2_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q[1] && cnt != '0) |=> (cnt == '0 && tx == '0));
endmodule

// File: rtl/spi_cfg_regs.sv
// Row-parity protected register file with a live column check.
module spi_cfg_regs #(
   parameter int DW   = 8,
   parameter int AW   = 4,
   parameter int NCFG = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW:0]   wr_word,
   input  logic [AW-1:0] rd_addr,
   output logic [DW:0]   rd_word,
   output logic          wr_bad,
   output logic          col_err
);
   localparam int ENT = NCFG + 1;
   localparam int RW  = DW + 1;
   localparam logic [RW-1:0] CFG_INIT = {{DW{1'b0}}, 1'b1};
   localparam logic [RW-1:0] COL_INIT = {{DW{1'b1}}, ~^{DW{1'b1}}};

   if (ENT > (1 << AW)) begin : g_bad_depth
      $error("address width too small for register count");
   end

   logic [ENT-1:0][RW-1:0] mem;
   logic [ENT-1:0][RW-1:0] init;
   logic                   in_range, par_ok;

   for (genvar g = 0; g < ENT; g++) begin : g_init
      if (g == NCFG) begin : g_col
         assign init[g] = COL_INIT;
      end else begin : g_cfg
         assign init[g] = CFG_INIT;
      end
   end

   assign in_range = wr_addr < AW'(ENT);
   assign par_ok   = ^wr_word;
   assign wr_bad   = wr_en & in_range & ~par_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= init;
      end else if (clr) begin
         mem <= init;
      end else if (wr_en && in_range && par_ok) begin
         for (int i = 0; i < ENT; i++)
            if (wr_addr == AW'(i)) mem[i] <= wr_word;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < ENT; i++)
         if (rd_addr == AW'(i)) rd_word = mem[i];
   end

   logic [DW-1:0] acc;
   always_comb begin
      acc = '0;
      for (int i = 0; i < ENT; i++) acc ^= mem[i][RW-1:1];
      col_err = acc != {DW{1'b1}};
   end

   logic all_odd;
   always_comb begin
      all_odd = 1'b1;
      for (int i = 0; i < ENT; i++) all_odd &= ^mem[i];
   end

   // R7: every stored entry keeps odd row parity
   a_r7_rows_odd: assert property (@(posedge clk) disable iff (!rst_n) all_odd);
   // R7: a refused write leaves the file untouched
   a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bad && !clr) |=> $stable(mem));
   // R8: writes at or above the status address change nothing
   a_r8_high_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_range && !clr) |=> $stable(mem));
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
   import spi_cfg_pkg::*;
#(
   parameter int AW   = 4,
   parameter int DW   = 8,
   parameter int NCFG = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdi,
   output logic sdo,
   output logic clamp_en,
   output logic sleep_mode,
   output logic agc_hold,
   output logic soft_rst,
   output logic row_err,
   output logic col_err
);
   localparam int RW        = DW + 1;
   localparam int FW        = OP_W + AW + RW;
   localparam int STAT_ADDR = NCFG + 1;

   if (DW < 5) begin : g_bad_dw
      $error("data width must hold the five status bits");
   end

   logic          frame_done, wr_bad, col_bad;
   logic [FW-1:0] frame, tx_word;
   op_e           op;
   logic [AW-1:0] addr;
   logic [RW-1:0] reg_rd, rd9;
   logic [DW-1:0] stat;
   logic          clamp_q, sleep_q, agc_q, srst_q, row_q;

   spi_cfg_link #(.FRAME_W(FW)) u_link (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .tx_load(frame_done), .tx_word(tx_word),
      .frame_done(frame_done), .frame(frame), .sdo(sdo));

   assign op   = op_e'(frame[FW-1 -: OP_W]);
   assign addr = frame[FW-1-OP_W -: AW];

   spi_cfg_regs #(.DW(DW), .AW(AW), .NCFG(NCFG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .clr(frame_done && op == OP_SRST),
      .wr_en(frame_done && op == OP_WRITE),
      .wr_addr(addr), .wr_word(frame[RW-1:0]),
      .rd_addr(addr), .rd_word(reg_rd),
      .wr_bad(wr_bad), .col_err(col_bad));

   always_comb begin
      stat      = '0;
      stat[4:0] = {agc_q, clamp_q, sleep_q, col_bad, row_q};
      rd9       = (addr == AW'(STAT_ADDR)) ? {stat, ~^stat} : reg_rd;
      tx_word   = (op == OP_READ) ? {rd9, {(FW-RW){1'b0}}} : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clamp_q <= 1'b0;
         sleep_q <= 1'b0;
         agc_q   <= 1'b0;
         srst_q  <= 1'b0;
         row_q   <= 1'b0;
      end else begin
         srst_q <= 1'b0;
         if (frame_done) begin
            sleep_q <= (op == OP_SLEEP);
            unique case (op)
               OP_CLAMP_ON:  clamp_q <= 1'b1;
               OP_CLAMP_OFF: clamp_q <= 1'b0;
               OP_AGC_ON:    agc_q   <= 1'b1;
               OP_AGC_OFF:   agc_q   <= 1'b0;
               OP_SRST: begin
                  srst_q  <= 1'b1;
                  clamp_q <= 1'b0;
                  agc_q   <= 1'b0;
                  row_q   <= 1'b0;
               end
               OP_WRITE:     if (wr_bad) row_q <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign clamp_en   = clamp_q;
   assign sleep_mode = sleep_q;
   assign agc_hold   = agc_q;
   assign soft_rst   = srst_q;
   assign row_err    = row_q;
   assign col_err    = col_bad;

   // R4: any completed non-sleep command wakes the block
   a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && op != OP_SLEEP) |=> !sleep_q);
   // R6: soft reset clears the control state and flags
   a_r6_srst: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && op == OP_SRST) |=> (srst_q && !clamp_q && !agc_q && !row_q));
   // R6: the soft reset pulse lasts one clock
   a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> !srst_q);
   // R3: clamp-on command takes effect
   a_r3_clamp_on: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && op == OP_CLAMP_ON) |=> clamp_q);
endmodule

// File: tb/spi_cfg_slave_test.sv
module spi_cfg_slave_test;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic sdo, clamp_en, sleep_mode, agc_hold, soft_rst, row_err, col_err;

   always #10 clk = ~clk; // 50 MHz

   spi_cfg_slave uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .sdo(sdo), .clamp_en(clamp_en), .sleep_mode(sleep_mode),
      .agc_hold(agc_hold), .soft_rst(soft_rst), .row_err(row_err),
      .col_err(col_err));

   int n_tests = 0, n_fail = 0, srst_seen = 0, cycles = 0;
   bit done = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (soft_rst) srst_seen <= srst_seen + 1;
   end

   // bench model
   logic [8:0]  m [7];
   logic        m_clamp, m_sleep, m_agc, m_row;
   logic [15:0] exp_tx;
   int          exp_srst;

   function automatic logic m_col();
      logic [7:0] acc = '0;
      for (int i = 0; i < 7; i++) acc ^= m[i][8:1];
      return acc != 8'hFF;
   endfunction

   function automatic void model_reset();
      for (int i = 0; i < 6; i++) m[i] = 9'b0_0000_0001;
      m[6] = {8'hFF, 1'b1};
      m_clamp = 0; m_sleep = 0; m_agc = 0; m_row = 0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic xfer(input logic [15:0] word, input int nbits, output logic [15:0] rx);
      rx = '0;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi = word[15-i];
         repeat (HALF) @(negedge clk);
         rx[15-i] = sdo;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic check_outputs(input string tag);
      check({tag, " R3 clamp"}, 32'(clamp_en), 32'(m_clamp));
      check({tag, " R4 sleep"}, 32'(sleep_mode), 32'(m_sleep));
      check({tag, " R5 agc"}, 32'(agc_hold), 32'(m_agc));
      check({tag, " R7 row_err"}, 32'(row_err), 32'(m_row));
      check({tag, " R10 col_err"}, 32'(col_err), 32'(m_col()));
      check({tag, " R6 soft_rst pulses"}, 32'(srst_seen), 32'(exp_srst));
   endtask

   task automatic do_frame(input logic [2:0] op, input logic [3:0] a,
                           input logic [7:0] d, input logic p);
      logic [15:0] rx;
      logic [7:0]  st;
      logic [15:0] nxt;
      xfer({op, a, d, p}, 16, rx);
      check("R9 read data on SDO", 32'(rx), 32'(exp_tx));
      st  = {3'b000, m_agc, m_clamp, m_sleep, m_col(), m_row};
      nxt = '0;
      case (op)
         3'd0: m_clamp = 1;
         3'd1: m_clamp = 0;
         3'd3: m_agc = 1;
         3'd4: m_agc = 0;
         3'd5: begin model_reset(); exp_srst++; end
         3'd6: if (a < 7) nxt = {m[a], 7'b0};
               else if (a == 7) nxt = {st, ~^st, 7'b0};
         3'd7: if (a < 7) begin
                  if (^{d, p}) m[a] = {d, p};
                  else m_row = 1;
               end
         default: ;
      endcase
      m_sleep = (op == 3'd2);
      exp_tx = nxt;
      check_outputs("frame");
   endtask

   task automatic partial(input logic [15:0] word, input int nbits);
      logic [15:0] rx;
      xfer(word, nbits, rx);
      exp_tx = '0;
      check_outputs("R2 partial");
   endtask

   initial begin
      while (!done && cycles < 190000) @(negedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_reset();
      exp_tx = '0; exp_srst = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 sdo low", 32'(sdo), 0);
      check_outputs("R12 reset");
      // R12 reset contents read back through SDO
      for (int i = 0; i < 7; i++) do_frame(3'd6, 4'(i), 8'h00, 1'b0);
      // R7 good write, then read back
      do_frame(3'd7, 4'd3, 8'hA5, ~^8'hA5);
      do_frame(3'd6, 4'd3, 8'h00, 1'b0);
      // R10 restore column consistency via the check byte
      do_frame(3'd7, 4'd6, 8'hFF ^ 8'hA5, ~^(8'hFF ^ 8'hA5));
      // R7 refused write
      do_frame(3'd7, 4'd2, 8'h3C, ^8'h3C);
      do_frame(3'd6, 4'd2, 8'h00, 1'b0);
      // R8 writes at or above the status address
      do_frame(3'd7, 4'd7, 8'hFF, 1'b0);
      do_frame(3'd7, 4'd9, 8'h12, 1'b1);
      do_frame(3'd6, 4'd12, 8'h00, 1'b0);
      // R11 status read
      do_frame(3'd6, 4'd7, 8'h00, 1'b0);
      do_frame(3'd0, 4'd0, 8'h00, 1'b0);
      // R13 junk fields on command frames
      do_frame(3'd3, 4'd5, 8'hE7, 1'b0);
      do_frame(3'd1, 4'd15, 8'h01, 1'b1);
      // R4 sleep then wake by another command
      do_frame(3'd2, 4'd0, 8'h00, 1'b0);
      do_frame(3'd6, 4'd7, 8'h00, 1'b0);
      do_frame(3'd0, 4'd0, 8'h00, 1'b0);
      // R2 truncated write, then read the target
      partial({3'd7, 4'd1, 8'h55, 1'b1}, 15);
      do_frame(3'd6, 4'd1, 8'h00, 1'b0);
      // R2 truncated read drops data
      do_frame(3'd6, 4'd3, 8'h00, 1'b0);
      partial({3'd0, 4'd0, 8'h00, 1'b0}, 5);
      do_frame(3'd0, 4'd0, 8'h00, 1'b0);
      // R6 soft reset
      do_frame(3'd5, 4'd2, 8'h77, 1'b0);
      do_frame(3'd6, 4'd6, 8'h00, 1'b0);
      // R1 random mix of frames
      for (int k = 0; k < 260; k++) begin
         logic [2:0] op;
         logic [3:0] a;
         logic [7:0] d;
         logic       p;
         op = 3'($urandom % 8);
         if (op == 3'd5 && ($urandom % 4) != 0) op = 3'd7;
         a  = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 8);
         d  = 8'($urandom);
         p  = ($urandom % 5 == 0) ? ^d : ~^d;
         if ($urandom % 10 == 0)
            partial({op, a, d, p}, 1 + int'($urandom % 15));
         else
            do_frame(op, a, d, p);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule